// File: doc/BRIEF.md
# Video Encoder Control Register File

This block is the software-visible control and status layer of a three-DAC video encoder. A simple word-addressed register bus with a byte address, separate read and write strobes and 32-bit data gives access to the encoder's setup: the common configuration word, one gain register per DAC, cable-detect control, a DAC test-mode selector, a copy-protection control word, an interrupt enable mask and a sticky event status word. The stored values drive the datapath through dedicated output ports.

Cable-detect and frame-timing logic outside this block report events as single-cycle pulses. Each pulse sets a sticky status bit that software clears by writing ones. The status bits are masked by the enables and ORed into one registered interrupt line. The configuration word also sets a DAC sample clock enable. The enable pulses at full, half or quarter rate and runs only while both the global enable and the pixel-clock enable are set.

Top module: `vid_enc_regs`

## Requirements
- R1: After reset the configuration word at offset 0x00 reads 0x00100000 (only bit 20, sync on channel 0, set). Every other register reads 0, and `irq` and `samp_en` are low.
- R2: The configuration word stores only bits 0–14 and 20–22 (mask 0x00707FFF). The other bits are discarded and read as 0. Bit 0 is the global enable, bit 3 the pixel clock enable and bits 2:1 the sample-rate code. Bits 14:12 select the output mode, bits 11:8 the standard, bit 7 interlace conversion, bit 6 the input format and bits 5:4 the data source.
- R3: The three DAC gain registers are at 0x28, 0x2c and 0x30, for DAC 0, 1 and 2. Each keeps bits 5:0 and drives its slice of `dac_gain`, with DAC 0 in the lowest bits.
- R4: The cable-detect control word at 0x34 keeps mask 0x00770701: bit 0 enable, bits 8–10 reference level, bits 16–18 long-monitor enables and bits 20–22 short-monitor enables. The test-mode register at 0x6c keeps bits 2:0. The copy-protection word at 0xdc keeps all 32 bits.
- R5: An address that is not a multiple of 4, is above 0xdc, or names no register reads as 0. A write to such an address changes no register.
- R6: A one-cycle pulse sets a status bit at 0x68: `evt_cable_long` sets bit 0, `evt_cable_short` bit 1, `evt_mon_end` bit 2 and `evt_frame_end` bit 13. The bit is visible on a read issued the next cycle and stays set until cleared.
- R7: Writing to 0x68 clears the status bits written as 1 and leaves the others. Writing 0xFFFFFFFF clears all of them. If an event and its clear arrive in the same cycle, the bit stays set.
- R8: The interrupt enable at 0x64 uses the same bit positions as the status word. `irq` is a register holding the OR of status AND enable. It rises one cycle after the status bit is set and falls one cycle after the status bit is cleared.
- R9: When enabled, `samp_en` pulses every cycle for rate code 0, every 2nd cycle for code 1, and every 4th cycle for codes 2 and 3.
- R10: `samp_en` stays low unless configuration bits 0 and 3 are both set.
- R11: `bus_rdata` updates on the clock edge that samples `bus_rd`, is valid the following cycle, and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_cable_long | input | 1 | Long-monitor cable event pulse |
| evt_cable_short | input | 1 | Short-monitor cable event pulse |
| evt_mon_end | input | 1 | Monitor-end event pulse |
| evt_frame_end | input | 1 | Frame-end event pulse |
| irq | output | 1 | Registered interrupt request |
| samp_en | output | 1 | DAC sample clock enable |
| cfg_out | output | 32 | Current configuration word |
| dac_gain | output | 18 | Gains of the three DACs, DAC 0 lowest |
| cdet_out | output | 32 | Cable-detect control word |
| tmode_out | output | 3 | DAC test mode |
| mvis_out | output | 32 | Copy-protection control word |

## Verification
Register writes use all-ones and mixed patterns, so the masks show which bits are kept and which are dropped. Writes to misaligned, out-of-range and unassigned addresses are followed by reads of nearby registers, which separates decode errors from storage errors. Events arrive one at a time, mixed with partial clears, and once together with their own clear in the same cycle. This shows whether status is sticky, whether clearing is selective, and which side wins the same-cycle race. The interrupt is watched cycle by cycle against enabled and masked events. Sample-enable pulses are counted over a fixed window for every rate code and for each half of the enable pair. This separates the three divide ratios, the reserved code and the gating.

// File: rtl/vid_enc_pkg.sv
package vid_enc_pkg;
  localparam int BUS_W = 32;

  localparam int OFS_CFG   = 'h00;
  localparam int OFS_GAIN0 = 'h28;
  localparam int OFS_CDET  = 'h34;
  localparam int OFS_IEN   = 'h64;
  localparam int OFS_STAT  = 'h68;
  localparam int OFS_TMODE = 'h6c;
  localparam int OFS_MVIS  = 'hdc;
  localparam int OFS_LAST  = 'hdc;

  localparam logic [BUS_W-1:0] CFG_RESET = 32'h0010_0000;
  localparam logic [BUS_W-1:0] CFG_MASK  = 32'h0070_7FFF;
  localparam logic [BUS_W-1:0] CDET_MASK = 32'h0077_0701;
  localparam logic [BUS_W-1:0] EVT_MASK  = 32'h0000_2007;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_RATE_LSB = 1;
  localparam int CFG_PCLK_BIT = 3;

  localparam int EV_LONG  = 0;
  localparam int EV_SHORT = 1;
  localparam int EV_MEND  = 2;
  localparam int EV_FRAME = 13;

  typedef enum logic [1:0] {
    RATE_FULL = 2'd0,
    RATE_DIV2 = 2'd1,
    RATE_DIV4 = 2'd2,
    RATE_RSVD = 2'd3
  } rate_e;
endpackage

// File: rtl/vid_enc_regfile.sv
module vid_enc_regfile
  import vid_enc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int N_DAC   = 3,
  parameter int GAIN_W  = 6,
  parameter int TMODE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [BUS_W-1:0]        wdata,
  input  logic [BUS_W-1:0]        stat_in,
  output logic [BUS_W-1:0]        rdata,
  output logic [BUS_W-1:0]        cfg_q,
  output logic [N_DAC*GAIN_W-1:0] gain_q,
  output logic [BUS_W-1:0]        cdet_q,
  output logic [BUS_W-1:0]        ien_q,
  output logic [TMODE_W-1:0]      tmode_q,
  output logic [BUS_W-1:0]        mvis_q,
  output logic [BUS_W-1:0]        stat_clr
);
  localparam int GAIN_STRIDE = 4;

  logic             legal;
  logic             hit_cfg, hit_cdet, hit_ien, hit_stat, hit_tmode, hit_mvis;
  logic [N_DAC-1:0] hit_gain;
  logic [BUS_W-1:0] rd_mux;

  assign legal     = (addr[1:0] == 2'b00) && (addr <= ADDR_W'(OFS_LAST));
  assign hit_cfg   = legal && (addr == ADDR_W'(OFS_CFG));
  assign hit_cdet  = legal && (addr == ADDR_W'(OFS_CDET));
  assign hit_ien   = legal && (addr == ADDR_W'(OFS_IEN));
  assign hit_stat  = legal && (addr == ADDR_W'(OFS_STAT));
  assign hit_tmode = legal && (addr == ADDR_W'(OFS_TMODE));
  assign hit_mvis  = legal && (addr == ADDR_W'(OFS_MVIS));

  assign stat_clr = (wr && hit_stat) ? (wdata & EVT_MASK) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= CFG_RESET;
      cdet_q  <= '0;
      ien_q   <= '0;
      tmode_q <= '0;
      mvis_q  <= '0;
    end else if (wr) begin
      if (hit_cfg)   cfg_q   <= wdata & CFG_MASK;
      if (hit_cdet)  cdet_q  <= wdata & CDET_MASK;
      if (hit_ien)   ien_q   <= wdata & EVT_MASK;
      if (hit_tmode) tmode_q <= wdata[TMODE_W-1:0];
      if (hit_mvis)  mvis_q  <= wdata;
    end
  end

  for (genvar g = 0; g < N_DAC; g++) begin : g_gain
    assign hit_gain[g] = legal && (addr == ADDR_W'(OFS_GAIN0 + GAIN_STRIDE * g));
    always_ff @(posedge clk) begin
      if (rst)
        gain_q[g*GAIN_W +: GAIN_W] <= '0;
      else if (wr && hit_gain[g])
        gain_q[g*GAIN_W +: GAIN_W] <= wdata[GAIN_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_cfg)   rd_mux = cfg_q;
    if (hit_cdet)  rd_mux = cdet_q;
    if (hit_ien)   rd_mux = ien_q;
    if (hit_stat)  rd_mux = stat_in;
    if (hit_tmode) rd_mux = BUS_W'(tmode_q);
    if (hit_mvis)  rd_mux = mvis_q;
    for (int i = 0; i < N_DAC; i++)
      if (hit_gain[i]) rd_mux = BUS_W'(gain_q[i*GAIN_W +: GAIN_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/vid_enc_evt.sv
module vid_enc_evt
  import vid_enc_pkg::*;
#(
  parameter logic [BUS_W-1:0] EV_MASK = EVT_MASK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] evt_in,
  input  logic [BUS_W-1:0] clr,
  input  logic [BUS_W-1:0] ien,
  output logic [BUS_W-1:0] stat_q,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= ((stat_q & ~clr) | evt_in) & EV_MASK;
      irq    <= |(stat_q & ien);
    end
  end
endmodule

// File: rtl/vid_enc_sampdiv.sv
module vid_enc_sampdiv
  import vid_enc_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  rate_e rate,
  output logic  samp_en
);
  localparam int PER_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [PER_W-1:0] period;

  always_comb begin
    case (rate)
      RATE_FULL: period = PER_W'(1);
      RATE_DIV2: period = PER_W'(2);
      default:   period = PER_W'(1 << CNT_W);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      samp_en <= 1'b0;
    end else begin
      samp_en <= (cnt == '0);
      if ({1'b0, cnt} >= period - PER_W'(1)) cnt <= '0;
      else                                   cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/vid_enc_regs.sv
module vid_enc_regs
  import vid_enc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int N_DAC   = 3,
  parameter int GAIN_W  = 6,
  parameter int TMODE_W = 3,
  parameter int CNT_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    evt_cable_long,
  input  logic                    evt_cable_short,
  input  logic                    evt_mon_end,
  input  logic                    evt_frame_end,
  output logic                    irq,
  output logic                    samp_en,
  output logic [31:0]             cfg_out,
  output logic [N_DAC*GAIN_W-1:0] dac_gain,
  output logic [31:0]             cdet_out,
  output logic [TMODE_W-1:0]      tmode_out,
  output logic [31:0]             mvis_out
);
  logic [BUS_W-1:0] stat_q, ien_q, stat_clr, evt_vec;
  logic             run;
  rate_e            rate;

  always_comb begin
    evt_vec           = '0;
    evt_vec[EV_LONG]  = evt_cable_long;
    evt_vec[EV_SHORT] = evt_cable_short;
    evt_vec[EV_MEND]  = evt_mon_end;
    evt_vec[EV_FRAME] = evt_frame_end;
  end

  vid_enc_regfile #(
    .ADDR_W(ADDR_W), .N_DAC(N_DAC), .GAIN_W(GAIN_W), .TMODE_W(TMODE_W)
  ) u_rf (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .stat_in(stat_q), .rdata(bus_rdata),
    .cfg_q(cfg_out), .gain_q(dac_gain), .cdet_q(cdet_out), .ien_q(ien_q),
    .tmode_q(tmode_out), .mvis_q(mvis_out), .stat_clr(stat_clr)
  );

  vid_enc_evt #(.EV_MASK(EVT_MASK)) u_evt (
    .clk(clk), .rst(rst), .evt_in(evt_vec), .clr(stat_clr), .ien(ien_q),
    .stat_q(stat_q), .irq(irq)
  );

  assign run  = cfg_out[CFG_EN_BIT] & cfg_out[CFG_PCLK_BIT];
  assign rate = rate_e'(cfg_out[CFG_RATE_LSB +: 2]);

  vid_enc_sampdiv #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .en(run), .rate(rate), .samp_en(samp_en)
  );
endmodule

// File: rtl/vid_enc_chk.sv
module vid_enc_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic        samp_en,
  input logic [31:0] cfg_w,
  input logic [31:0] stat_w,
  input logic [31:0] ien_w,
  input logic        evt_long,
  input logic        evt_frame
);
  AST_RESET_SIGNATURE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_w == 32'h0010_0000)); // R1
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
    evt_long |=> stat_w[0]); // R6
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    evt_frame |=> stat_w[13]); // R7
  AST_IRQ_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(stat_w & ien_w))); // R8
  AST_HALF_RATE_GAP: assert property (@(posedge clk) disable iff (rst)
    (samp_en && cfg_w[2:1] == 2'd1 && $stable(cfg_w[3:0])) |=> !samp_en); // R9
  AST_SAMP_GATED: assert property (@(posedge clk) disable iff (rst)
    !(cfg_w[0] && cfg_w[3]) |=> !samp_en); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

bind vid_enc_regs vid_enc_chk u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
  .samp_en(samp_en), .cfg_w(cfg_out), .stat_w(stat_q), .ien_w(ien_q),
  .evt_long(evt_cable_long), .evt_frame(evt_frame_end)
);

// File: tb/sim_vid_enc_regs.sv
module sim_vid_enc_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, cfg_out, cdet_out, mvis_out;
  logic        e_long = 0, e_short = 0, e_mend = 0, e_frame = 0;
  logic        irq, samp_en;
  logic [17:0] dac_gain;
  logic [2:0]  tmode_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  vid_enc_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .evt_cable_long(e_long),
    .evt_cable_short(e_short), .evt_mon_end(e_mend), .evt_frame_end(e_frame),
    .irq(irq), .samp_en(samp_en), .cfg_out(cfg_out), .dac_gain(dac_gain),
    .cdet_out(cdet_out), .tmode_out(tmode_out), .mvis_out(mvis_out)
  );

  // behavioural reference model
  logic [31:0] m_cfg, m_cd, m_ien, m_stat, m_mv, m_rdata, n_stat;
  logic [5:0]  m_gain [3];
  logic [2:0]  m_tm;
  logic        m_irq, m_samp;
  int          m_ph, per;

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: return m_cfg;
      8'h28: return {26'd0, m_gain[0]};
      8'h2c: return {26'd0, m_gain[1]};
      8'h30: return {26'd0, m_gain[2]};
      8'h34: return m_cd;
      8'h64: return m_ien;
      8'h68: return m_stat;
      8'h6c: return {29'd0, m_tm};
      8'hdc: return m_mv;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 32'h0010_0000; m_cd = 0; m_ien = 0; m_stat = 0; m_mv = 0;
      m_rdata = 0; m_tm = 0; m_irq = 0; m_samp = 0; m_ph = 0;
      for (int i = 0; i < 3; i++) m_gain[i] = 0;
    end else begin
      if (rd) m_rdata = mread(addr);
      m_irq = |(m_stat & m_ien);
      if (!(m_cfg[0] && m_cfg[3])) begin
        m_ph = 0; m_samp = 0;
      end else begin
        per = (m_cfg[2:1] == 0) ? 1 : (m_cfg[2:1] == 1) ? 2 : 4;
        m_samp = (m_ph == 0);
        m_ph = (m_ph + 1 >= per) ? 0 : m_ph + 1;
      end
      n_stat = m_stat;
      if (wr && addr == 8'h68) n_stat = n_stat & ~(wdata & 32'h2007);
      n_stat[0]  = n_stat[0]  | e_long;
      n_stat[1]  = n_stat[1]  | e_short;
      n_stat[2]  = n_stat[2]  | e_mend;
      n_stat[13] = n_stat[13] | e_frame;
      if (wr) begin
        case (addr)
          8'h00: m_cfg = wdata & 32'h0070_7FFF;
          8'h28: m_gain[0] = wdata[5:0];
          8'h2c: m_gain[1] = wdata[5:0];
          8'h30: m_gain[2] = wdata[5:0];
          8'h34: m_cd = wdata & 32'h0077_0701;
          8'h64: m_ien = wdata & 32'h2007;
          8'h6c: m_tm = wdata[2:0];
          8'hdc: m_mv = wdata;
          default: ;
        endcase
      end
      m_stat = n_stat;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      chk("R8 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R9 samp_en", {31'd0, samp_en}, {31'd0, m_samp});
      chk("R11 rdata", rdata, m_rdata);
      chk("R2 cfg_out", cfg_out, m_cfg);
      chk("R3 dac_gain", {14'd0, dac_gain}, {14'd0, m_gain[2], m_gain[1], m_gain[0]});
      chk("R4 cdet/tmode/mvis", cdet_out ^ mvis_out ^ {29'd0, tmode_out},
          m_cd ^ m_mv ^ {29'd0, m_tm});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_samp(input logic [31:0] cfgv, input int exp, input string tag);
    int n;
    wr_reg(8'h00, cfgv);
    idle(4);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (samp_en) n++;
    end
    chk(tag, n, exp);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 samp_en low", {31'd0, samp_en}, 32'd0);
    rd_reg(8'h00, 32'h0010_0000, "R1 signature");
    rd_reg(8'h68, 32'd0, "R1 status");
    rd_reg(8'h34, 32'd0, "R1 cable ctrl");
    // R2 configuration mask
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_reg(8'h00, 32'h0070_7FFF, "R2 cfg mask");
    wr_reg(8'h00, 32'h0010_C6A0);
    rd_reg(8'h00, 32'h0010_46A0, "R2 cfg mixed");
    // R3 gains
    wr_reg(8'h28, 32'hFFFF_FFC5);
    wr_reg(8'h2c, 32'h0000_003F);
    wr_reg(8'h30, 32'h0000_012A);
    rd_reg(8'h28, 32'h05, "R3 gain0");
    rd_reg(8'h2c, 32'h3F, "R3 gain1");
    rd_reg(8'h30, 32'h2A, "R3 gain2");
    chk("R3 gain port", {14'd0, dac_gain}, {14'd0, 6'h2A, 6'h3F, 6'h05});
    // R4
    wr_reg(8'h34, 32'hFFFF_FFFF);
    rd_reg(8'h34, 32'h0077_0701, "R4 cable mask");
    wr_reg(8'h6c, 32'hFF);
    rd_reg(8'h6c, 32'h7, "R4 test mode");
    wr_reg(8'hdc, 32'hDEAD_BEEF);
    rd_reg(8'hdc, 32'hDEAD_BEEF, "R4 protect word");
    // R5 unmapped, misaligned, out of range
    wr_reg(8'h04, 32'hFFFF_FFFF);
    wr_reg(8'h29, 32'h0);
    wr_reg(8'h2a, 32'h0);
    wr_reg(8'he0, 32'h1234);
    wr_reg(8'hdd, 32'h0);
    rd_reg(8'h04, 32'd0, "R5 hole");
    rd_reg(8'h29, 32'd0, "R5 misaligned");
    rd_reg(8'he0, 32'd0, "R5 above range");
    rd_reg(8'h28, 32'h05, "R5 gain0 untouched");
    rd_reg(8'hdc, 32'hDEAD_BEEF, "R5 protect untouched");
    // R6 events
    @(negedge clk); e_long = 1; @(negedge clk); e_long = 0;
    rd_reg(8'h68, 32'h1, "R6 long");
    @(negedge clk); e_short = 1; @(negedge clk); e_short = 0;
    rd_reg(8'h68, 32'h3, "R6 short");
    @(negedge clk); e_mend = 1; @(negedge clk); e_mend = 0;
    rd_reg(8'h68, 32'h7, "R6 monitor end");
    @(negedge clk); e_frame = 1; @(negedge clk); e_frame = 0;
    idle(5);
    rd_reg(8'h68, 32'h2007, "R6 sticky");
    // R7 write-one-to-clear
    wr_reg(8'h68, 32'h1);
    rd_reg(8'h68, 32'h2006, "R7 partial clear");
    @(negedge clk); addr = 8'h68; wdata = 32'h2006; wr = 1; e_frame = 1;
    @(negedge clk); wr = 0; e_frame = 0;
    rd_reg(8'h68, 32'h2000, "R7 event wins");
    wr_reg(8'h68, 32'hFFFF_FFFF);
    rd_reg(8'h68, 32'd0, "R7 clear all");
    // R8 interrupt
    wr_reg(8'h64, 32'h2000);
    @(negedge clk); e_frame = 1; @(negedge clk); e_frame = 0;
    chk("R8 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 irq rises", {31'd0, irq}, 32'd1);
    wr_reg(8'h68, 32'h2000);
    chk("R8 irq still high", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R8 irq falls", {31'd0, irq}, 32'd0);
    @(negedge clk); e_long = 1; @(negedge clk); e_long = 0;
    idle(3);
    chk("R8 masked event", {31'd0, irq}, 32'd0);
    wr_reg(8'h64, 32'h1);
    @(negedge clk);
    chk("R8 enable pending", {31'd0, irq}, 32'd1);
    wr_reg(8'h68, 32'hFFFF_FFFF);
    idle(2);
    // R9 / R10 sample enable
    count_samp(32'h0000_0009, 16, "R9 full rate");
    count_samp(32'h0000_000B, 8, "R9 half rate");
    count_samp(32'h0000_000D, 4, "R9 quarter rate");
    count_samp(32'h0000_000F, 4, "R9 code 3");
    count_samp(32'h0000_0001, 0, "R10 pixel clock off");
    count_samp(32'h0000_000E, 0, "R10 global off");
    // R11 read data hold
    rd_reg(8'hdc, 32'hDEAD_BEEF, "R11 read");
    wr_reg(8'hdc, 32'h0);
    idle(3);
    chk("R11 hold", rdata, 32'hDEAD_BEEF);
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule